// File: doc/BRIEF.md
# Receive Ring Packet Writer

This block takes a received byte stream, framed by first-byte and last-byte markers, and stores each frame in a circular buffer in on-chip RAM. The buffer is organised in 256-byte pages and is bounded by a start page and a stop page. Every frame begins on a page boundary and is preceded by a 4-byte header. The header holds a status byte, the page where the next frame will begin, and the stored length.

When the first byte of a frame arrives, the writer decides whether the frame can be taken. It refuses the frame if the receiver is halted or if the free space between the current page and the boundary page cannot hold a maximum-size frame. A refused frame is dropped whole and leaves no trace in RAM. An accepted frame has its data written from byte 4 of the current page, one byte per clock. The data wraps from the stop page back to the start page. After the last byte the header is filled in, the current page advances to the next-page value, and a one-cycle interrupt-set pulse is raised.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset `cur_pg` equals parameter RESET_PG (default 0), and `busy`, `rx_irq_set` and `mem_we` are low.
- R2: A `cur_load` pulse while idle sets `cur_pg` to `cur_wdata` on the next edge. A `cur_load` while a frame is being stored has no effect.
- R3: A frame whose first byte arrives while `stop_cmd` is high is refused: no RAM write, no interrupt, `cur_pg` unchanged.
- R4: Free pages are `bound_pg - cur_pg` when `cur_pg < bound_pg`, and otherwise `(ring_stop_pg - ring_start_pg) - (cur_pg - bound_pg)`. A frame is refused (nothing written, `cur_pg` kept, no interrupt) when free pages × 256 is below MAX_FRAME + 4 bytes.
- R5: Data byte k of an accepted frame is written to byte address `(cur_pg << 8) + 4 + k`. An address that reaches `ring_stop_pg << 8` continues at `ring_start_pg << 8`. Exactly frame length + 4 writes occur per frame.
- R6: The header occupies byte offsets 0..3 of the starting page and holds 0x01, the next page, stored length bits 7:0, and stored length bits 15:8, where stored length = frame length + 4.
- R7: The next page is `cur_pg + ceil((stored length + 4) / 256)`. If that value is greater than or equal to `ring_stop_pg`, the ring size `ring_stop_pg - ring_start_pg` is subtracted from it.
- R8: Once the header is written, `cur_pg` takes the next page, `rx_irq_set` is high for exactly one cycle, and `busy` is low in that same cycle.
- R9: `busy` is high from the edge that accepts the first byte until the `cur_pg` update, and it is high on every cycle in which `mem_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_cmd | input | 1 | Receiver halted; new frames are refused |
| ring_start_pg | input | PAGE_W | First page of the ring |
| ring_stop_pg | input | PAGE_W | Page one past the end of the ring |
| bound_pg | input | PAGE_W | Oldest page not yet released by the reader |
| cur_load | input | 1 | Host write strobe for the current page |
| cur_wdata | input | PAGE_W | Value for the current page |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Stream byte |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | PAGE_W+8 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| cur_pg | output | PAGE_W | Current page pointer |
| busy | output | 1 | A frame is being stored |
| rx_irq_set | output | 1 | One-cycle receive-interrupt set pulse |

## Verification
Random frame lengths are sent while the boundary sits at the current page, so every frame is accepted and the data path and next-page arithmetic are exercised across many page counts. A second random phase places the boundary anywhere in the ring, which mixes acceptance and refusal on both sides of the free-space formula. Directed frames of 1, 248 and 249 bytes sit on either side of a page-count step. A 700-byte frame starting two pages below the stop page shows that the data wrap and the next-page wrap are separate operations. Free space of exactly six and of five pages, the halt input, and a host load during storage each isolate one refusal or ignore rule.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_HDR,
    ST_DONE
  } rxw_state_e;

  localparam logic [7:0] RX_STATUS_GOOD = 8'h01;
  localparam int unsigned HDR_BYTES = 4;
  localparam int unsigned CRC_BYTES = 4;
endpackage

// File: rtl/rxw_room_check.sv
module rxw_room_check #(
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned MAX_FRAME = 1514
) (
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [PAGE_W-1:0] bound_pg,
  input  logic [PAGE_W-1:0] cur_pg,
  output logic              room_ok
);
  localparam int unsigned NEED_BYTES = MAX_FRAME + rxw_pkg::HDR_BYTES;
  // smallest page count whose byte size is not below NEED_BYTES
  localparam int unsigned NEED_PG = (NEED_BYTES + 255) / 256;

  logic [PAGE_W-1:0] ring_pg;
  logic [PAGE_W-1:0] free_pg;

  always_comb begin
    ring_pg = stop_pg - start_pg;
    if (cur_pg < bound_pg) free_pg = bound_pg - cur_pg;
    else                   free_pg = ring_pg - (cur_pg - bound_pg);
    room_ok = (32'(free_pg) >= NEED_PG);
  end
endmodule

// File: rtl/rxw_next_page.sv
module rxw_next_page #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned LEN_W  = 16
) (
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  output logic [PAGE_W-1:0] next_pg
);
  localparam int unsigned SUM_W = ((LEN_W > PAGE_W) ? LEN_W : PAGE_W) + 2;
  localparam int unsigned EXTRA = rxw_pkg::HDR_BYTES + rxw_pkg::CRC_BYTES + 255;

  logic [SUM_W-1:0] span_pg;
  logic [SUM_W-1:0] raw_pg;
  logic [SUM_W-1:0] ring_pg;
  logic [SUM_W-1:0] wrap_pg;

  always_comb begin
    span_pg = (SUM_W'(frame_len) + SUM_W'(EXTRA)) >> 8;
    raw_pg  = SUM_W'(cur_pg) + span_pg;
    ring_pg = SUM_W'(stop_pg) - SUM_W'(start_pg);
    wrap_pg = (raw_pg >= SUM_W'(stop_pg)) ? raw_pg - ring_pg : raw_pg;
    next_pg = PAGE_W'(wrap_pg);
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MAX_FRAME = 1514,
  parameter logic [PAGE_W-1:0] RESET_PG = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stop_cmd,
  input  logic [PAGE_W-1:0]   ring_start_pg,
  input  logic [PAGE_W-1:0]   ring_stop_pg,
  input  logic [PAGE_W-1:0]   bound_pg,
  input  logic                cur_load,
  input  logic [PAGE_W-1:0]   cur_wdata,
  input  logic                in_valid,
  input  logic                in_sof,
  input  logic                in_eof,
  input  logic [7:0]          in_data,
  output logic                mem_we,
  output logic [PAGE_W+7:0]   mem_addr,
  output logic [7:0]          mem_wdata,
  output logic [PAGE_W-1:0]   cur_pg,
  output logic                busy,
  output logic                rx_irq_set
);
  import rxw_pkg::*;

  localparam int unsigned ADDR_W = PAGE_W + 8;

  rxw_state_e        state;
  logic [ADDR_W-1:0] wr_ptr;
  logic [LEN_W-1:0]  len_q;
  logic [1:0]        hdr_idx;
  logic [PAGE_W-1:0] cur_pg_q;
  logic              busy_q;
  logic              irq_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;

  logic              room_ok;
  logic              accept_ok;
  logic [PAGE_W-1:0] next_pg;
  logic [ADDR_W-1:0] ptr_inc;
  logic [ADDR_W-1:0] ptr_adv;
  logic [15:0]       stored_len;
  logic [7:0]        hdr_byte;

  rxw_room_check #(.PAGE_W(PAGE_W), .MAX_FRAME(MAX_FRAME)) u_room (
    .start_pg (ring_start_pg),
    .stop_pg  (ring_stop_pg),
    .bound_pg (bound_pg),
    .cur_pg   (cur_pg_q),
    .room_ok  (room_ok)
  );

  rxw_next_page #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_next (
    .cur_pg    (cur_pg_q),
    .frame_len (len_q),
    .start_pg  (ring_start_pg),
    .stop_pg   (ring_stop_pg),
    .next_pg   (next_pg)
  );

  always_comb begin
    accept_ok  = room_ok && !stop_cmd;
    ptr_inc    = wr_ptr + ADDR_W'(1);
    ptr_adv    = (ptr_inc == {ring_stop_pg, 8'h00}) ? {ring_start_pg, 8'h00} : ptr_inc;
    stored_len = 16'(len_q) + 16'(HDR_BYTES);
    case (hdr_idx)
      2'd0:    hdr_byte = RX_STATUS_GOOD;
      2'd1:    hdr_byte = 8'(next_pg);
      2'd2:    hdr_byte = stored_len[7:0];
      default: hdr_byte = stored_len[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wr_ptr   <= '0;
      len_q    <= '0;
      hdr_idx  <= '0;
      cur_pg_q <= RESET_PG;
      busy_q   <= 1'b0;
      irq_q    <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      we_q  <= 1'b0;
      irq_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid && in_sof) begin
            if (accept_ok) begin
              we_q    <= 1'b1;
              addr_q  <= {cur_pg_q, 8'(HDR_BYTES)};
              wdata_q <= in_data;
              wr_ptr  <= {cur_pg_q, 8'(HDR_BYTES + 1)};
              len_q   <= LEN_W'(1);
              busy_q  <= 1'b1;
              hdr_idx <= '0;
              state   <= in_eof ? ST_HDR : ST_DATA;
            end else if (!in_eof) begin
              state <= ST_DROP;
            end
          end else if (cur_load) begin
            cur_pg_q <= cur_wdata;
          end
        end
        ST_DATA: begin
          if (in_valid) begin
            we_q    <= 1'b1;
            addr_q  <= wr_ptr;
            wdata_q <= in_data;
            wr_ptr  <= ptr_adv;
            len_q   <= len_q + LEN_W'(1);
            if (in_eof) begin
              hdr_idx <= '0;
              state   <= ST_HDR;
            end
          end
        end
        ST_DROP: begin
          if (in_valid && in_eof) state <= ST_IDLE;
        end
        ST_HDR: begin
          we_q    <= 1'b1;
          addr_q  <= {cur_pg_q, 6'b0, hdr_idx};
          wdata_q <= hdr_byte;
          hdr_idx <= hdr_idx + 2'd1;
          if (hdr_idx == 2'd3) state <= ST_DONE;
        end
        ST_DONE: begin
          cur_pg_q <= next_pg;
          irq_q    <= 1'b1;
          busy_q   <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign cur_pg     = cur_pg_q;
  assign busy       = busy_q;
  assign rx_irq_set = irq_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_irq_set |=> !rx_irq_set); // R8
  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    rx_irq_set |-> !busy); // R8
  AST_CUR_IN_RING: assert property (@(posedge clk) disable iff (rst)
    rx_irq_set |-> (cur_pg >= ring_start_pg && cur_pg < ring_stop_pg)); // R7
  AST_HALT_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && in_valid && in_sof && stop_cmd) |=> (!busy && !mem_we)); // R3
  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy); // R9
  AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr >= {ring_start_pg, 8'h00} && mem_addr < {ring_stop_pg, 8'h00})); // R5
  AST_CUR_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && state != ST_DONE) |=> $stable(cur_pg)); // R2
endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
  localparam int START_PG = 'h40;
  localparam int STOP_PG  = 'h80;
  localparam int MAXF     = 1514;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stop_cmd = 1'b0;
  logic [7:0] bound_pg = 8'h40;
  logic       cur_load = 1'b0;
  logic [7:0] cur_wdata = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] cur_pg;
  logic       busy;
  logic       rx_irq_set;

  int checks = 0;
  int errors = 0;
  int wr_count = 0;
  int irq_count = 0;
  int cur_model = 0;
  logic [7:0] shadow [int];
  logic [7:0] fdata [0:2047];

  always #5 clk = ~clk;

  rx_ring_writer u_rx_ring_writer (
    .clk(clk), .rst(rst), .stop_cmd(stop_cmd),
    .ring_start_pg(8'(START_PG)), .ring_stop_pg(8'(STOP_PG)),
    .bound_pg(bound_pg), .cur_load(cur_load), .cur_wdata(cur_wdata),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_pg(cur_pg), .busy(busy), .rx_irq_set(rx_irq_set)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        shadow[int'(mem_addr)] = mem_wdata;
        wr_count++;
      end
      if (rx_irq_set) irq_count++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int calc_next(input int cur, input int len);
    int n;
    n = cur + (len + 8 + 255) / 256;
    if (n >= STOP_PG) n -= (STOP_PG - START_PG);
    return n;
  endfunction

  function automatic bit calc_room(input int cur, input int bnd, input bit halted);
    int avail;
    if (cur < bnd) avail = bnd - cur;
    else           avail = (STOP_PG - START_PG) - (cur - bnd);
    return !halted && (avail * 256 >= MAXF + 4);
  endfunction

  function automatic int peek(input int a);
    return shadow.exists(a) ? int'(shadow[a]) : -1;
  endfunction

  task automatic load_cur(input int v);
    @(negedge clk);
    cur_load = 1'b1;
    cur_wdata = 8'(v);
    @(negedge clk);
    cur_load = 1'b0;
    cur_model = v;
  endtask

  task automatic send_frame(input int len, input bit poke, input string dtag);
    int base, exp_next, bad, first_bad, t, a;
    bit exp_ok;
    base = cur_model;
    exp_ok = calc_room(cur_model, int'(bound_pg), stop_cmd);
    exp_next = calc_next(base, len);
    shadow.delete();
    wr_count = 0;
    irq_count = 0;
    for (int i = 0; i < len; i++) fdata[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 1 && exp_ok) chk(busy == 1'b1, "R9 busy after first byte", busy, 1);
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = (i == len - 1);
      in_data = fdata[i];
      cur_load = poke && (i == len / 2) && (i > 0);
      cur_wdata = 8'h55;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cur_load = 1'b0;
    if (exp_ok) begin
      t = 0;
      while (!rx_irq_set && t < 20) begin
        @(negedge clk);
        t++;
      end
      chk(rx_irq_set == 1'b1, "R8 interrupt pulse", rx_irq_set, 1);
      chk(int'(cur_pg) == exp_next, poke ? "R2 load ignored while busy" : "R7 next page", cur_pg, exp_next);
      chk(busy == 1'b0, "R8 busy clear at update", busy, 0);
      repeat (2) @(negedge clk);
      chk(irq_count == 1, "R8 single pulse", irq_count, 1);
      chk(wr_count == len + 4, "R5 write count", wr_count, len + 4);
      bad = 0;
      first_bad = -1;
      for (int i = 0; i < len; i++) begin
        a = base * 256 + 4 + i;
        if (a >= STOP_PG * 256) a -= (STOP_PG - START_PG) * 256;
        if (peek(a) != int'(fdata[i])) begin
          bad++;
          if (first_bad < 0) first_bad = i;
        end
      end
      chk(bad == 0, "R5 data placement", first_bad, -1);
      chk(peek(base * 256) == 1, "R6 status byte", peek(base * 256), 1);
      chk(peek(base * 256 + 1) == exp_next, "R6 next page byte", peek(base * 256 + 1), exp_next);
      chk(peek(base * 256 + 2) == ((len + 4) & 255), "R6 length low", peek(base * 256 + 2), (len + 4) & 255);
      chk(peek(base * 256 + 3) == ((len + 4) >> 8), "R6 length high", peek(base * 256 + 3), (len + 4) >> 8);
      cur_model = exp_next;
    end else begin
      repeat (10) @(negedge clk);
      chk(wr_count == 0, {dtag, " refused frame writes nothing"}, wr_count, 0);
      chk(irq_count == 0, {dtag, " refused frame no interrupt"}, irq_count, 0);
      chk(int'(cur_pg) == cur_model, {dtag, " refused frame keeps page"}, cur_pg, cur_model);
    end
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cur_pg == 8'h00, "R1 reset page", cur_pg, 0);
    chk(busy == 1'b0 && rx_irq_set == 1'b0 && mem_we == 1'b0, "R1 reset flags",
        {busy, rx_irq_set, mem_we}, 0);

    load_cur('h40);
    chk(int'(cur_pg) == 'h40, "R2 idle load", cur_pg, 'h40);

    // full ring available: boundary follows the current page
    for (int k = 0; k < 14; k++) begin
      bound_pg = 8'(cur_model);
      send_frame($urandom_range(1, 700), 1'b0, "R4");
    end

    // page-count steps
    bound_pg = 8'(cur_model); send_frame(1, 1'b0, "R4");
    bound_pg = 8'(cur_model); send_frame(248, 1'b0, "R4");
    bound_pg = 8'(cur_model); send_frame(249, 1'b0, "R4");

    // data wrap and next-page wrap
    load_cur('h7E); bound_pg = 8'h7E;
    send_frame(700, 1'b0, "R4");
    chk(cur_model == 'h41, "R7 wrapped next page", cur_model, 'h41);

    // host load during storage is ignored
    bound_pg = 8'(cur_model); send_frame(300, 1'b1, "R2");

    // free-space boundaries
    load_cur('h50); bound_pg = 8'h56; send_frame(100, 1'b0, "R4");
    send_frame(100, 1'b0, "R4");
    bound_pg = 8'h40; load_cur('h7C); send_frame(60, 1'b0, "R4");
    load_cur('h7A); send_frame(60, 1'b0, "R4");

    // halted receiver
    stop_cmd = 1'b1; bound_pg = 8'(cur_model);
    send_frame(80, 1'b0, "R3");
    stop_cmd = 1'b0;

    // random boundary placement
    for (int k = 0; k < 12; k++) begin
      bound_pg = 8'(START_PG + $urandom_range(0, 63));
      send_frame($urandom_range(1, 500), 1'b0, "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule